// File: doc/BRIEF.md
# Length-Steered Serial Configuration Port

This block is a three-wire write port for a frequency synthesizer's setup registers. A host drives a data line, a shift clock and an active-low enable. The port carries no address or steering bits. While enable is low, the port counts the shift-clock pulses. When enable returns high, that count alone decides which register takes the bits that were shifted in.

The port holds three registers:

- an 8-bit control word
- a 16-bit main divider
- a 15-bit reference divider

A burst of nine to thirteen clocks asks for a device reset. The port then raises a one-cycle soft-reset pulse and writes no register. All three port inputs are brought into the system clock domain through flop synchronizers. The serial clock can therefore run at any rate well below the system clock, including arbitrarily slow or stop-and-go clocking.

A serial output carries the shifted stream onward so that devices can be chained. It changes only after falling shift-clock edges.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset, the control word, the main divider and the reference divider are all zero, and the serial output and the soft-reset pulse are low.
- R2: While enable is low, each rising shift-clock edge captures one data bit. Bits arrive most significant first, so the last bit shifted becomes bit 0 of the written value.
- R3: A transfer of exactly 8 clocks writes the control word.
- R4: A transfer of exactly 16 clocks writes the main divider.
- R5: A transfer of exactly 15 clocks writes the reference divider.
- R6: A transfer of 24 clocks also writes the reference divider. Only the last 15 bits shifted are kept; the first 9 are dropped.
- R7: A transfer of 9, 10, 11, 12 or 13 clocks writes no register. It produces exactly one soft-reset pulse, one system clock wide.
- R8: A transfer of any other length writes nothing and produces no pulse. This covers zero clocks, lengths up to 32 that match no rule, and transfers longer than 32 clocks (the counter saturates).
- R9: No register changes while a transfer is in progress. A write takes effect only after enable returns high.
- R10: Writes may come in any order. Each write changes only its own target register.
- R11: The serial output changes only after a falling shift-clock edge while enable is low. After the falling edge that follows the k-th rising edge of a transfer, the output shows the bit captured at rising edge k-15. For k below 16 it shows 0.
- R12: Correct operation does not depend on the shift-clock rate. Long pauses between edges give the same result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdi | input | 1 | Serial data in |
| sclk | input | 1 | Serial shift clock |
| sen_n | input | 1 | Transfer enable, active low |
| sdo | output | 1 | Serial data out, updated after falling shift-clock edges |
| ctrl_q | output | 8 | Control word |
| ndiv_q | output | 16 | Main divider value |
| rdiv_q | output | 15 | Reference divider value |
| soft_rst | output | 1 | One-cycle reset pulse from a reset-length burst |

## Verification
The hardest case to reach from the ports is the serial output of a long transfer. Its value only becomes meaningful once sixteen rising edges have filled the shift path. It must also be observed between edges, after the falling edge has been synchronized.

A dedicated scenario shifts a 24-bit pattern and samples the output after every falling edge. It expects zeros for the first fifteen edges and the early bits afterwards.

Length decoding is covered by sweeping every reset length and a spread of non-matching lengths, including zero and more than 32 clocks. Each of these runs checks that no register moved and that the pulse count is right.

// File: rtl/scp_pkg.sv
package scp_pkg;
   typedef enum logic [2:0] {
      TGT_NONE,
      TGT_CTRL,
      TGT_NDIV,
      TGT_RDIV,
      TGT_RESET
   } target_e;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
   parameter int unsigned      W      = 1,
   parameter int unsigned      STAGES = 2,
   parameter logic [W-1:0]     RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   generate
      if (STAGES < 2) begin : g_bad
         $error("scp_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {STAGES{RST_VAL}};
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/scp_shifter.sv
module scp_shifter #(
   parameter int unsigned SHIFT_W = 16,
   parameter int unsigned CNT_W   = 6,
   parameter int unsigned CNT_SAT = 33
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sdi_s,
   input  logic               sclk_s,
   input  logic               sen_n_s,
   output logic [SHIFT_W-1:0] shreg,
   output logic [CNT_W-1:0]   cnt,
   output logic               done,
   output logic               sdo
);
   logic sclk_d, sen_d;
   logic rise, fall, en_fall, active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         sen_d  <= 1'b1;
      end else begin
         sclk_d <= sclk_s;
         sen_d  <= sen_n_s;
      end
   end

   assign rise    = sclk_s & ~sclk_d;
   assign fall    = ~sclk_s & sclk_d;
   assign en_fall = sen_d & ~sen_n_s;
   assign done    = ~sen_d & sen_n_s;
   assign active  = ~sen_n_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         cnt   <= '0;
      end else if (en_fall) begin
         shreg <= '0;
         cnt   <= '0;
      end else if (active && rise) begin
         shreg <= {shreg[SHIFT_W-2:0], sdi_s};
         if (cnt != CNT_W'(CNT_SAT)) cnt <= cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               sdo <= 1'b0;
      else if (active && fall)  sdo <= shreg[SHIFT_W-1];
   end

   AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
      (active && rise && !en_fall) |=> (shreg[0] == $past(sdi_s)))     // R2
      else $error("shift did not capture data bit");
   AST_SDO_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !(active && fall) |=> $stable(sdo))                               // R11
      else $error("sdo moved without falling shift edge");
   AST_CNT_NOT_PAST_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_W'(CNT_SAT)) |=> (cnt == CNT_W'(CNT_SAT) || cnt == '0)) // R8
      else $error("bit counter left saturation");
endmodule

// File: rtl/scp_commit.sv
module scp_commit
   import scp_pkg::*;
#(
   parameter int unsigned SHIFT_W    = 16,
   parameter int unsigned CNT_W      = 6,
   parameter int unsigned C_W        = 8,
   parameter int unsigned N_W        = 16,
   parameter int unsigned R_W        = 15,
   parameter int unsigned R_LONG_LEN = 24,
   parameter int unsigned RST_LO     = 9,
   parameter int unsigned RST_HI     = 13
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               done,
   input  logic [CNT_W-1:0]   cnt,
   input  logic [SHIFT_W-1:0] shreg,
   output logic [C_W-1:0]     ctrl_q,
   output logic [N_W-1:0]     ndiv_q,
   output logic [R_W-1:0]     rdiv_q,
   output logic               soft_rst
);
   target_e tgt;

   always_comb begin
      tgt = TGT_NONE;
      if (cnt == CNT_W'(C_W))                                 tgt = TGT_CTRL;
      else if (cnt == CNT_W'(N_W))                            tgt = TGT_NDIV;
      else if (cnt == CNT_W'(R_W) || cnt == CNT_W'(R_LONG_LEN)) tgt = TGT_RDIV;
      else if (cnt >= CNT_W'(RST_LO) && cnt <= CNT_W'(RST_HI))  tgt = TGT_RESET;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         ndiv_q   <= '0;
         rdiv_q   <= '0;
         soft_rst <= 1'b0;
      end else begin
         soft_rst <= done && (tgt == TGT_RESET);
         if (done) begin
            case (tgt)
               TGT_CTRL: ctrl_q <= shreg[C_W-1:0];
               TGT_NDIV: ndiv_q <= shreg[N_W-1:0];
               TGT_RDIV: rdiv_q <= shreg[R_W-1:0];
               default:  ;
            endcase
         end
      end
   end

   AST_HOLD_UNLESS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> $stable({ctrl_q, ndiv_q, rdiv_q}))                      // R9
      else $error("register changed outside commit");
   AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !soft_rst)                                           // R7
      else $error("soft reset wider than one cycle");
   AST_RST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |-> $stable({ctrl_q, ndiv_q, rdiv_q}))                   // R7
      else $error("reset burst wrote a register");
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
   import scp_pkg::*;
#(
   parameter int unsigned C_W         = 8,
   parameter int unsigned N_W         = 16,
   parameter int unsigned R_W         = 15,
   parameter int unsigned R_LONG_LEN  = 24,
   parameter int unsigned RST_LO      = 9,
   parameter int unsigned RST_HI      = 13,
   parameter int unsigned LEN_CAP     = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           sdi,
   input  logic           sclk,
   input  logic           sen_n,
   output logic           sdo,
   output logic [C_W-1:0] ctrl_q,
   output logic [N_W-1:0] ndiv_q,
   output logic [R_W-1:0] rdiv_q,
   output logic           soft_rst
);
   localparam int unsigned SHIFT_W = max3(C_W, N_W, R_W);
   localparam int unsigned CNT_SAT = LEN_CAP + 1;
   localparam int unsigned CNT_W   = $clog2(CNT_SAT + 1);

   generate
      if (R_LONG_LEN < R_W || R_LONG_LEN > LEN_CAP) begin : g_bad_rlen
         $error("long reference transfer length out of range");
      end
      if (RST_LO > RST_HI || RST_HI > LEN_CAP) begin : g_bad_rst
         $error("reset length window invalid");
      end
      if (SHIFT_W < 2) begin : g_bad_w
         $error("register widths too small");
      end
   endgenerate

   logic [2:0] pins_s;
   logic [SHIFT_W-1:0] shreg;
   logic [CNT_W-1:0]   cnt;
   logic               done;

   scp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sen_n, sclk, sdi}),
      .q     (pins_s)
   );

   scp_shifter #(.SHIFT_W(SHIFT_W), .CNT_W(CNT_W), .CNT_SAT(CNT_SAT)) i_shifter (
      .clk     (clk),
      .rst_n   (rst_n),
      .sdi_s   (pins_s[0]),
      .sclk_s  (pins_s[1]),
      .sen_n_s (pins_s[2]),
      .shreg   (shreg),
      .cnt     (cnt),
      .done    (done),
      .sdo     (sdo)
   );

   scp_commit #(
      .SHIFT_W(SHIFT_W), .CNT_W(CNT_W), .C_W(C_W), .N_W(N_W), .R_W(R_W),
      .R_LONG_LEN(R_LONG_LEN), .RST_LO(RST_LO), .RST_HI(RST_HI)
   ) i_commit (
      .clk      (clk),
      .rst_n    (rst_n),
      .done     (done),
      .cnt      (cnt),
      .shreg    (shreg),
      .ctrl_q   (ctrl_q),
      .ndiv_q   (ndiv_q),
      .rdiv_q   (rdiv_q),
      .soft_rst (soft_rst)
   );

   AST_PULSE_ONLY_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(soft_rst) |-> $past(done))                                  // R7
      else $error("soft reset without enable release");
endmodule

// File: tb/test_serial_cfg_port.sv
module test_serial_cfg_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sdi = 1'b0;
   logic        sclk = 1'b0;
   logic        sen_n = 1'b1;
   logic        sdo;
   logic [7:0]  ctrl_q;
   logic [15:0] ndiv_q;
   logic [14:0] rdiv_q;
   logic        soft_rst;

   int errors = 0;
   int checks = 0;
   int pulses = 0;

   always #5 clk = ~clk;

   serial_cfg_port i_serial_cfg_port (
      .clk(clk), .rst_n(rst_n), .sdi(sdi), .sclk(sclk), .sen_n(sen_n),
      .sdo(sdo), .ctrl_q(ctrl_q), .ndiv_q(ndiv_q), .rdiv_q(rdiv_q),
      .soft_rst(soft_rst)
   );

   always @(negedge clk) if (soft_rst) pulses++;

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_regs(input string tag, input logic [7:0] c, input logic [15:0] n,
                           input logic [14:0] r);
      chk(ctrl_q == c, {tag, " ctrl"}, 32'(ctrl_q), 32'(c));
      chk(ndiv_q == n, {tag, " ndiv"}, 32'(ndiv_q), 32'(n));
      chk(rdiv_q == r, {tag, " rdiv"}, 32'(rdiv_q), 32'(r));
   endtask

   // Shifts len bits MSB first; checks registers do not move mid-transfer (R9)
   task automatic send(input logic [31:0] val, input int len, input int gap);
      logic [7:0]  c0 = ctrl_q;
      logic [15:0] n0 = ndiv_q;
      logic [14:0] r0 = rdiv_q;
      sen_n = 1'b0;
      waitc(gap);
      for (int i = 0; i < len; i++) begin
         sdi = val[(len - 1 - i) % 32];
         waitc(gap);
         sclk = 1'b1;
         waitc(gap);
         sclk = 1'b0;
         waitc(gap);
      end
      waitc(6);
      chk_regs("R9 mid-transfer", c0, n0, r0);
      sen_n = 1'b1;
      waitc(8);
   endtask

   task automatic t_reset;
      chk_regs("R1 reset", 8'h00, 16'h0000, 15'h0000);
      chk(sdo == 1'b0, "R1 sdo", 32'(sdo), 0);
      chk(soft_rst == 1'b0, "R1 soft_rst", 32'(soft_rst), 0);
   endtask

   task automatic t_ctrl;
      send(32'hA5, 8, 4);
      chk_regs("R2 R3 ctrl write", 8'hA5, 16'h0000, 15'h0000);
      send(32'h01, 8, 4);
      chk(ctrl_q == 8'h01, "R2 msb-first", 32'(ctrl_q), 32'h01);
   endtask

   task automatic t_ndiv;
      send(32'h1234, 16, 4);
      chk_regs("R4 ndiv write", 8'h01, 16'h1234, 15'h0000);
   endtask

   task automatic t_rdiv;
      send(32'h5AC3, 15, 4);
      chk_regs("R5 rdiv 15", 8'h01, 16'h1234, 15'h5AC3);
      send(32'hABCDEF, 24, 4);
      chk_regs("R6 rdiv 24", 8'h01, 16'h1234, 15'h4DEF);
   endtask

   task automatic t_reset_len;
      for (int len = 9; len <= 13; len++) begin
         int p0 = pulses;
         send(32'hFFFF_FFFF, len, 3);
         chk(pulses - p0 == 1, $sformatf("R7 pulse count len=%0d", len),
             32'(pulses - p0), 1);
         chk_regs("R7 no write", 8'h01, 16'h1234, 15'h4DEF);
      end
   endtask

   task automatic t_other_len;
      int lens[8] = '{0, 7, 14, 17, 23, 25, 32, 40};
      foreach (lens[k]) begin
         int p0 = pulses;
         send(32'hFFFF_FFFF, lens[k], 3);
         chk(pulses == p0, $sformatf("R8 no pulse len=%0d", lens[k]), 32'(pulses - p0), 0);
         chk_regs($sformatf("R8 no write len=%0d", lens[k]), 8'h01, 16'h1234, 15'h4DEF);
      end
   endtask

   task automatic t_order;
      send(32'h0777, 15, 4);
      chk_regs("R10 r first", 8'h01, 16'h1234, 15'h0777);
      send(32'h9C, 8, 4);
      chk_regs("R10 c second", 8'h9C, 16'h1234, 15'h0777);
      send(32'hBEEF, 16, 4);
      chk_regs("R10 n third", 8'h9C, 16'hBEEF, 15'h0777);
      send(32'h42, 8, 4);
      chk_regs("R10 c again", 8'h42, 16'hBEEF, 15'h0777);
   endtask

   task automatic t_sdo;
      logic [23:0] v = 24'hC3_5A_96;
      sen_n = 1'b0;
      waitc(4);
      for (int k = 1; k <= 24; k++) begin
         logic exp;
         sdi = v[24 - k];
         waitc(4);
         sclk = 1'b1;
         waitc(4);
         sclk = 1'b0;
         waitc(5);
         exp = (k >= 16) ? v[39 - k] : 1'b0;
         chk(sdo == exp, $sformatf("R11 sdo after edge %0d", k), 32'(sdo), 32'(exp));
      end
      sen_n = 1'b1;
      waitc(8);
      chk(rdiv_q == 15'h5A96, "R6 rdiv from sdo frame", 32'(rdiv_q), 32'h5A96);
   endtask

   task automatic t_slow;
      send(32'h3C, 8, 60);
      chk(ctrl_q == 8'h3C, "R12 slow clocking", 32'(ctrl_q), 32'h3C);
   endtask

   initial begin
      waitc(3);
      rst_n = 1'b1;
      waitc(4);
      t_reset();
      t_ctrl();
      t_ndiv();
      t_rdiv();
      t_reset_len();
      t_other_len();
      t_order();
      t_sdo();
      t_slow();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule